// File: doc/BRIEF.md
# Microprogram Sequencer with Control Memory

This block is a microprogrammed control engine. A single clocked control address register selects one word of a read-only control memory. The memory is purely combinational, so the selected microinstruction appears on its outputs without any read strobe. Each microinstruction holds two kinds of field. A 16-bit control word goes straight out to the datapath. The sequencing fields (branch type, condition select and branch target) tell the next-address logic where to go. The next-address logic is also combinational. It chooses among four sources: the incremented address, the target from the current word, an external mapping address, or the fixed start address 0.

On every rising clock edge, the micro-operations named by the current control word take effect in the datapath. On the same edge the computed next address loads into the register. Condition-dependent branches test one of three external status bits, or a constant true. A start request or a reset sends the engine back to address 0.

Top module: `useq_engine`

## Requirements
- R1: When `rst` is high at a rising edge, `cur_addr` becomes 0 and `ctrl_word` shows word 0 (0x0001). Reset wins over every other input.
- R2: When `start` is high (and `rst` low) at a rising edge, `cur_addr` becomes 0, whatever the current microinstruction says.
- R3: A word with branch type 0 (continue) loads the current address plus one.
- R4: A word with branch type 1 (conditional jump) loads its 7-bit target when the selected condition is 1.
- R5: A conditional jump whose selected condition is 0 loads the current address plus one.
- R6: Condition select values pick the tested condition: 0 picks constant 1, 1 picks `status[0]`, 2 picks `status[1]`, and 3 picks `status[2]`. Status bits that are not selected have no effect.
- R7: A word with branch type 2 (map) loads `map_addr`.
- R8: A word with branch type 3 (home) loads address 0.
- R9: Incrementing from address 127 wraps to address 0.
- R10: `ctrl_word` depends only on `cur_addr` and follows the built-in program below. Any address not listed holds `{8'hA5, 1'b0, addr}` with branch type continue.

| Address | Control word | Branch type | Condition select | Target |
|---------|--------------|-------------|------------------|--------|
| 0 | 0x0001 | jump | 1 | 10 |
| 1 | 0x0002 | continue | – | – |
| 2 | 0x0004 | jump | 0 | 20 |
| 10 | 0x0010 | map | – | – |
| 20 | 0x0020 | jump | 2 | 30 |
| 21 | 0x0040 | home | – | – |
| 30 | 0x0080 | jump | 3 | 127 |
| 31 | 0x0100 | home | – | – |
| 127 | 0x8000 | continue | – | – |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the address register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset to address 0 |
| start | input | 1 | Request to restart at address 0 |
| map_addr | input | 7 | External address used by map-type words |
| status | input | 3 | External condition bits |
| ctrl_word | output | 16 | Control word of the current microinstruction |
| cur_addr | output | 7 | Current control address |

## Verification
On every cycle, the assertions check each address transition against the branch type and condition of the word that was current before the edge. They also check reset and start priority, the wrap of the increment, and that `ctrl_word` holds steady while the address does. Only the bench scenarios can show that the stored program itself is correct. That covers the actual word values at each address, the routes the program takes under each status pattern, and that unselected status bits leave the path unchanged.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W  = 7;
    localparam int CW_W    = 16;
    localparam int STAT_W  = 3;
    localparam int ADDR_HI = (1 << ADDR_W) - 1;

    typedef enum logic [1:0] {
        BT_NEXT = 2'd0,
        BT_JUMP = 2'd1,
        BT_MAP  = 2'd2,
        BT_HOME = 2'd3
    } btype_e;

    typedef enum logic [1:0] {
        CS_ONE = 2'd0,
        CS_ST0 = 2'd1,
        CS_ST1 = 2'd2,
        CS_ST2 = 2'd3
    } csel_e;

    typedef struct packed {
        logic [CW_W-1:0]   cw;
        csel_e             csel;
        btype_e            btype;
        logic [ADDR_W-1:0] target;
    } uword_t;

    localparam logic [ADDR_W-1:0] HOME_ADDR = '0;

    function automatic uword_t mk_word(logic [CW_W-1:0] cw, csel_e cs,
                                       btype_e bt, int unsigned tgt);
        uword_t w;
        w.cw     = cw;
        w.csel   = cs;
        w.btype  = bt;
        w.target = ADDR_W'(tgt);
        return w;
    endfunction

    // Built-in microprogram; unlisted locations hold a filler word.
    function automatic uword_t rom_word(logic [ADDR_W-1:0] a);
        uword_t w;
        case (a)
            7'd0:   w = mk_word(16'h0001, CS_ST0, BT_JUMP, 10);
            7'd1:   w = mk_word(16'h0002, CS_ONE, BT_NEXT, 0);
            7'd2:   w = mk_word(16'h0004, CS_ONE, BT_JUMP, 20);
            7'd10:  w = mk_word(16'h0010, CS_ONE, BT_MAP,  0);
            7'd20:  w = mk_word(16'h0020, CS_ST1, BT_JUMP, 30);
            7'd21:  w = mk_word(16'h0040, CS_ONE, BT_HOME, 0);
            7'd30:  w = mk_word(16'h0080, CS_ST2, BT_JUMP, 127);
            7'd31:  w = mk_word(16'h0100, CS_ONE, BT_HOME, 0);
            7'd127: w = mk_word(16'h8000, CS_ONE, BT_NEXT, 0);
            default: w = mk_word({8'hA5, 1'b0, a}, CS_ONE, BT_NEXT, 0);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output uword_t            word
);
    // Pure combinational lookup: output follows the address, no strobe.
    always_comb begin
        word = rom_word(addr);
    end
endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
(
    input  csel_e             csel,
    input  logic [STAT_W-1:0] status,
    output logic              cond
);
    always_comb begin
        unique case (csel)
            CS_ONE:  cond = 1'b1;
            CS_ST0:  cond = status[0];
            CS_ST1:  cond = status[1];
            CS_ST2:  cond = status[2];
            default: cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
(
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] car,
    input  uword_t            word,
    input  logic              cond,
    input  logic [ADDR_W-1:0] map_addr,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] inc;

    always_comb begin
        inc = car + ADDR_W'(1);   // natural wrap at the top address
        if (rst || start) begin
            nxt = HOME_ADDR;
        end else begin
            unique case (word.btype)
                BT_NEXT: nxt = inc;
                BT_JUMP: nxt = cond ? word.target : inc;
                BT_MAP:  nxt = map_addr;
                BT_HOME: nxt = HOME_ADDR;
                default: nxt = HOME_ADDR;
            endcase
        end
    end
endmodule

// File: rtl/useq_engine.sv
module useq_engine
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] map_addr,
    input  logic [STAT_W-1:0] status,
    output logic [CW_W-1:0]   ctrl_word,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [ADDR_W-1:0] car;
    logic [ADDR_W-1:0] nxt;
    uword_t            uword;
    logic              cond;

    useq_rom u_rom (
        .addr (car),
        .word (uword)
    );

    useq_cond_mux u_cond (
        .csel   (uword.csel),
        .status (status),
        .cond   (cond)
    );

    useq_next_addr u_nxt (
        .rst      (rst),
        .start    (start),
        .car      (car),
        .word     (uword),
        .cond     (cond),
        .map_addr (map_addr),
        .nxt      (nxt)
    );

    // The only clocked element of the engine.
    always_ff @(posedge clk) begin
        car <= nxt;
    end

    assign cur_addr  = car;
    assign ctrl_word = uword.cw;
endmodule

// File: rtl/useq_engine_chk.sv
module useq_engine_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] map_addr,
    input logic [STAT_W-1:0] status,
    input logic [CW_W-1:0]   ctrl_word,
    input logic [ADDR_W-1:0] cur_addr,
    input uword_t            uw
);
    logic sel_true;
    always_comb begin
        case (uw.csel)
            CS_ONE:  sel_true = 1'b1;
            CS_ST0:  sel_true = status[0];
            CS_ST1:  sel_true = status[1];
            default: sel_true = status[2];
        endcase
    end

    AST_RESET_HOME: assert property (@(posedge clk)
        rst |=> (cur_addr == '0)); // R1

    AST_START_HOME: assert property (@(posedge clk) disable iff (rst)
        start |=> (cur_addr == '0)); // R2

    AST_CONTINUE_INC: assert property (@(posedge clk) disable iff (rst)
        (!start && uw.btype == BT_NEXT)
        |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1))); // R3

    AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!start && uw.btype == BT_JUMP && sel_true)
        |=> (cur_addr == $past(uw.target))); // R4

    AST_JUMP_FALL: assert property (@(posedge clk) disable iff (rst)
        (!start && uw.btype == BT_JUMP && !sel_true)
        |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1))); // R5

    AST_MAP_EXT: assert property (@(posedge clk) disable iff (rst)
        (!start && uw.btype == BT_MAP) |=> (cur_addr == $past(map_addr))); // R7

    AST_HOME_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!start && uw.btype == BT_HOME) |=> (cur_addr == '0)); // R8

    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!start && uw.btype == BT_NEXT && cur_addr == ADDR_W'(ADDR_HI))
        |=> (cur_addr == '0)); // R9

    AST_CW_STEADY: assert property (@(posedge clk) disable iff (rst)
        $stable(cur_addr) |-> $stable(ctrl_word)); // R10
endmodule

bind useq_engine useq_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .map_addr  (map_addr),
    .status    (status),
    .ctrl_word (ctrl_word),
    .cur_addr  (cur_addr),
    .uw        (uword)
);

// File: tb/test_useq_engine.sv
module test_useq_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  map_addr = '0;
    logic [2:0]  status = '0;
    logic [15:0] ctrl_word;
    logic [6:0]  cur_addr;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    useq_engine i_useq_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .map_addr  (map_addr),
        .status    (status),
        .ctrl_word (ctrl_word),
        .cur_addr  (cur_addr)
    );

    typedef struct packed {
        logic        st;
        logic [2:0]  stat;
        logic [6:0]  map;
        logic [6:0]  ea;
        logic [15:0] ecw;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    // Inputs applied at the current address; expected address/word after one edge.
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'b000, 7'd0,   7'd1,   16'h0002, 4'd5},  // R5 0: st0 low
        '{1'b0, 3'b000, 7'd0,   7'd2,   16'h0004, 4'd3},  // R3 1 -> 2
        '{1'b0, 3'b000, 7'd0,   7'd20,  16'h0020, 4'd4},  // R4 const-true jump
        '{1'b0, 3'b010, 7'd0,   7'd30,  16'h0080, 4'd6},  // R6 st1 chosen
        '{1'b0, 3'b000, 7'd0,   7'd31,  16'h0100, 4'd5},  // R5 st2 low
        '{1'b0, 3'b000, 7'd0,   7'd0,   16'h0001, 4'd8},  // R8 home
        '{1'b0, 3'b001, 7'd0,   7'd10,  16'h0010, 4'd4},  // R4 st0 high
        '{1'b0, 3'b000, 7'd126, 7'd126, 16'hA57E, 4'd7},  // R7 map, R10 filler
        '{1'b0, 3'b000, 7'd0,   7'd127, 16'h8000, 4'd3},  // R3
        '{1'b0, 3'b000, 7'd0,   7'd0,   16'h0001, 4'd9},  // R9 wrap
        '{1'b0, 3'b001, 7'd0,   7'd10,  16'h0010, 4'd4},  // R4
        '{1'b0, 3'b000, 7'd40,  7'd40,  16'hA528, 4'd7},  // R7
        '{1'b1, 3'b000, 7'd0,   7'd0,   16'h0001, 4'd2},  // R2 start overrides
        '{1'b0, 3'b110, 7'd0,   7'd1,   16'h0002, 4'd6},  // R6 unselected bits ignored
        '{1'b0, 3'b000, 7'd0,   7'd2,   16'h0004, 4'd3},  // R3
        '{1'b0, 3'b000, 7'd0,   7'd20,  16'h0020, 4'd4},  // R4
        '{1'b0, 3'b101, 7'd0,   7'd21,  16'h0040, 4'd6},  // R6 st1 low only
        '{1'b0, 3'b000, 7'd0,   7'd0,   16'h0001, 4'd8},  // R8
        '{1'b0, 3'b001, 7'd0,   7'd10,  16'h0010, 4'd4},  // R4
        '{1'b0, 3'b000, 7'd30,  7'd30,  16'h0080, 4'd7},  // R7 map to listed word, R10
        '{1'b0, 3'b100, 7'd0,   7'd127, 16'h8000, 4'd6}   // R6 st2 chosen
    };

    task automatic check(input int req, input logic [6:0] ea, input logic [15:0] ecw);
        checks++;
        if (cur_addr !== ea || ctrl_word !== ecw) begin
            fails++;
            $display("FAIL R%0d: addr=%0d word=%h expected addr=%0d word=%h",
                     req, cur_addr, ctrl_word, ea, ecw);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL R1: watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        @(negedge clk);
        check(1, 7'd0, 16'h0001);            // R1 reset state
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            start    = VECS[i].st;
            status   = VECS[i].stat;
            map_addr = VECS[i].map;
            step();
            check(int'(VECS[i].req), VECS[i].ea, VECS[i].ecw);
        end
        start = 1'b0; status = '0;

        // R10: address held by reset, word stays the listed one
        // R1: reset and start together at address 127 -> 0
        rst = 1'b1; start = 1'b1;
        step();
        check(1, 7'd0, 16'h0001);
        // R1: reset held with a true condition at address 0 keeps address 0
        start = 1'b0; status = 3'b001;
        step();
        check(1, 7'd0, 16'h0001);
        rst = 1'b0; status = 3'b000;
        step();
        check(5, 7'd1, 16'h0002);            // R5
        // R2: start from mid-program at address 1
        start = 1'b1;
        step();
        check(2, 7'd0, 16'h0001);
        start = 1'b0;
        // R1: reset mid-run from address 10
        status = 3'b001;
        step();
        check(4, 7'd10, 16'h0010);           // R4
        rst = 1'b1; map_addr = 7'd90;
        step();
        check(1, 7'd0, 16'h0001);
        rst = 1'b0; status = 3'b000;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule